// File: doc/BRIEF.md
# Serial Channel DMA Request and Acknowledge Logic

This block sits beside the receive and transmit FIFOs of one serial channel and turns their status into active-low DMA request lines, and the DMA controller's active-low acknowledge inputs into one-cycle FIFO read and write strobes. A two-bit mode input selects what the pins mean. In half-duplex mode a single request and a single acknowledge serve whichever direction is enabled. In full-duplex mode one pair serves the receiver and the other pair serves the transmitter. In non-DMA mode both request pins are general-purpose outputs that follow software register bits.

Software can always read the registered levels of the two acknowledge pins, so they work as general-purpose inputs whenever single-address transfers are off. A done-in input flags the last DMA load into the transmit FIFO. An open-drain done output is pulled low for a fixed number of cycles after the last DMA read from the receive FIFO, or after the transmitted-character counter reaches terminal count.

Top module: `dma_req_ctl`

## Requirements
- R1: The mode input encodes 0 = no DMA, 1 = half-duplex, 2 = full-duplex, and 3 behaves as no DMA. With no DMA, req1_n equals the inverse of gpo1 and req2_n equals the inverse of gpo2, and no strobe is ever produced.
- R2: In half-duplex, req1_n is low exactly when (rx_en and rx_not_empty) or (tx_en and tx_not_full), in the same cycle as those inputs. req2_n follows the inverse of gpo2.
- R3: In full-duplex, req1_n is low exactly when rx_en and rx_not_empty, and req2_n is low exactly when tx_en and tx_not_full. Both respond in the same cycle as their inputs.
- R4: Strobes occur only in a DMA mode with single_addr high. A strobe lasts one cycle and fires when an acknowledge that was sampled high at the previous clock edge is now low.
- R5: In half-duplex, a falling ack1_n gives rx_rd if rx_en is high, otherwise tx_wr if tx_en is high. ack2_n is ignored.
- R6: In full-duplex, a falling ack1_n gives rx_rd if rx_en is high, and a falling ack2_n gives tx_wr if tx_en is high. Both strobes may fire in the same cycle.
- R7: ack_pins reads {ack2_n, ack1_n} as sampled at the last clock edge, in every mode.
- R8: tx_last is high when tx_wr is high and done_in_n is low.
- R9: done_oe goes high in the cycle after an rx_rd with rx_last high, or after tx_tc is high. It then stays high for DONE_HOLD cycles, and a new trigger reloads the count. done_o is a constant 0.
- R10: After reset, ack_pins is 2'b11, done_oe is 0 and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 none, 1 half-duplex, 2 full-duplex, 3 none |
| single_addr | input | 1 | Single-address acknowledge transfers enabled |
| rx_en | input | 1 | Receiver enabled |
| tx_en | input | 1 | Transmitter enabled |
| rx_not_empty | input | 1 | Receive FIFO holds at least one character |
| tx_not_full | input | 1 | Transmit FIFO can accept a character |
| gpo1 | input | 1 | Software bit for request pin 1 |
| gpo2 | input | 1 | Software bit for request pin 2 |
| ack1_n | input | 1 | Shared / receive acknowledge, active low |
| ack2_n | input | 1 | Transmit acknowledge, active low |
| done_in_n | input | 1 | Last-load marker from the DMA controller, active low |
| rx_last | input | 1 | Current receive read is the final DMA transfer |
| tx_tc | input | 1 | Transmitted-character count at terminal count |
| req1_n | output | 1 | Shared / receive request or general output |
| req2_n | output | 1 | Transmit request or general output |
| rx_rd | output | 1 | Receive FIFO read strobe |
| tx_wr | output | 1 | Transmit FIFO load strobe |
| tx_last | output | 1 | Current load is the final DMA load |
| ack_pins | output | 2 | Registered acknowledge levels {ack2_n, ack1_n} |
| done_oe | output | 1 | Done pin output enable |
| done_o | output | 1 | Done pin drive value, always 0 |

## Verification
In full-duplex single-address mode, a receive read and a transmit load can occur in the same cycle. The bench provokes this by pulling both acknowledges low on the same edge. It checks that rx_rd and tx_wr both fire and that each depends only on its own enable. The sweep covers every mode, enable and acknowledge-pattern combination. Each result is compared against a routing function written in the bench, so any crosstalk between the two paths, or rx priority leaking into full-duplex, shows up as a mismatch.

// File: rtl/dma_req_pkg.sv
// Shared types for the DMA request logic.
// Assumes a two-bit mode field where code 3 is reserved and treated as no DMA.
package dma_req_pkg;
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_HALF = 2'd1,
        MODE_FULL = 2'd2,
        MODE_RSVD = 2'd3
    } dma_mode_e;

    // Folds the reserved code onto the no-DMA mode.
    function automatic dma_mode_e decode_mode(input logic [1:0] raw);
        return (raw == 2'd3) ? MODE_NONE : dma_mode_e'(raw);
    endfunction
endpackage

// File: rtl/dma_req_gen.sv
// Request pin generator: drives the two active-low request pins from FIFO
// status or from software bits, depending on the mode.
// Assumes the FIFO status inputs are synchronous to clk. The output is purely
// combinational, so a request drops in the same cycle as its condition.
module dma_req_gen
    import dma_req_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dma_mode_e mode,
    input  logic      rx_en,
    input  logic      tx_en,
    input  logic      rx_not_empty,
    input  logic      tx_not_full,
    input  logic      gpo1,
    input  logic      gpo2,
    output logic      req1_n,
    output logic      req2_n
);
    logic rx_want;
    logic tx_want;

    // Each direction's service condition.
    always_comb begin
        rx_want = rx_en & rx_not_empty;
        tx_want = tx_en & tx_not_full;
    end

    // Pin meaning selected by the mode.
    always_comb begin
        unique case (mode)
            MODE_HALF: begin
                req1_n = ~(rx_want | tx_want);
                req2_n = ~gpo2;
            end
            MODE_FULL: begin
                req1_n = ~rx_want;
                req2_n = ~tx_want;
            end
            default: begin
                req1_n = ~gpo1;
                req2_n = ~gpo2;
            end
        endcase
    end

    p_full_rx_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FULL && !rx_not_empty) |-> req1_n);
    p_half_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALF && !rx_en && !tx_en) |-> req1_n);
endmodule

// File: rtl/dma_ack_route.sv
// Acknowledge edge detection and routing: samples the active-low acknowledge
// pins, gives the sampled levels back for software reads, and turns a falling
// acknowledge into a one-cycle FIFO strobe in single-address DMA modes.
// Assumes the acknowledges are already synchronous to clk.
module dma_ack_route
    import dma_req_pkg::*;
#(
    parameter int N_ACK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dma_mode_e        mode,
    input  logic             single_addr,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic [N_ACK-1:0] ack_n,
    output logic [N_ACK-1:0] ack_pins,
    output logic             rx_rd,
    output logic             tx_wr
);
    logic [N_ACK-1:0] ack_prev;
    logic [N_ACK-1:0] fall;

    for (genvar i = 0; i < N_ACK; i++) begin : g_ack
        // Sample each acknowledge pin; reset to the idle (high) level.
        always_ff @(posedge clk) begin
            if (!rst_n) ack_prev[i] <= 1'b1;
            else        ack_prev[i] <= ack_n[i];
        end
        // Detect high-at-last-edge, low-now.
        always_comb fall[i] = ack_prev[i] & ~ack_n[i];
    end

    assign ack_pins = ack_prev;

    // Routes the falling edges to the FIFO strobes for the active mode.
    always_comb begin
        rx_rd = 1'b0;
        tx_wr = 1'b0;
        if (single_addr) begin
            unique case (mode)
                MODE_HALF: begin
                    if (rx_en)      rx_rd = fall[0];
                    else if (tx_en) tx_wr = fall[0];
                end
                MODE_FULL: begin
                    rx_rd = fall[0] & rx_en;
                    tx_wr = fall[1] & tx_en;
                end
                default: ;
            endcase
        end
    end

    p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |=> !rx_rd);
    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !tx_wr);
    p_half_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALF) |-> !(rx_rd && tx_wr));
    p_none_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NONE) |-> !(rx_rd || tx_wr));
endmodule

// File: rtl/dma_done_ctl.sv
// Done pin control: marks the final transmit load from the done input, and
// holds the open-drain done output enabled for a fixed number of cycles after
// a final receive read or a transmit terminal count.
// Assumes the triggers are single-cycle pulses; a new trigger restarts the hold.
module dma_done_ctl #(
    parameter int DONE_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_rd,
    input  logic rx_last,
    input  logic tx_wr,
    input  logic tx_tc,
    input  logic done_in_n,
    output logic tx_last,
    output logic done_oe
);
    localparam int CNT_W = $clog2(DONE_HOLD + 1);
    localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(DONE_HOLD);

    logic [CNT_W-1:0] hold_cnt;
    logic             trig;

    // Events that end a transfer block.
    always_comb begin
        trig    = (rx_rd & rx_last) | tx_tc;
        tx_last = tx_wr & ~done_in_n;
    end

    // Hold counter for the done output enable.
    always_ff @(posedge clk) begin
        if (!rst_n)              hold_cnt <= '0;
        else if (trig)           hold_cnt <= HOLD_LD;
        else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end

    assign done_oe = (hold_cnt != '0);

    p_done_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> done_oe);
    p_last_needs_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_wr);
endmodule

// File: rtl/dma_req_ctl.sv
// Top level of the per-channel DMA handshake logic. Joins the request
// generator, the acknowledge router and the done control.
// Assumes every input is synchronous to clk; the FIFOs are outside.
module dma_req_ctl #(
    parameter int DONE_HOLD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       single_addr,
    input  logic       rx_en,
    input  logic       tx_en,
    input  logic       rx_not_empty,
    input  logic       tx_not_full,
    input  logic       gpo1,
    input  logic       gpo2,
    input  logic       ack1_n,
    input  logic       ack2_n,
    input  logic       done_in_n,
    input  logic       rx_last,
    input  logic       tx_tc,
    output logic       req1_n,
    output logic       req2_n,
    output logic       rx_rd,
    output logic       tx_wr,
    output logic       tx_last,
    output logic [1:0] ack_pins,
    output logic       done_oe,
    output logic       done_o
);
    import dma_req_pkg::*;

    dma_mode_e mode_d;

    // Decode the raw mode field once for both consumers.
    always_comb mode_d = decode_mode(mode);

    dma_req_gen u_req (
        .clk(clk), .rst_n(rst_n), .mode(mode_d),
        .rx_en(rx_en), .tx_en(tx_en),
        .rx_not_empty(rx_not_empty), .tx_not_full(tx_not_full),
        .gpo1(gpo1), .gpo2(gpo2),
        .req1_n(req1_n), .req2_n(req2_n)
    );

    dma_ack_route #(.N_ACK(2)) u_ack (
        .clk(clk), .rst_n(rst_n), .mode(mode_d),
        .single_addr(single_addr), .rx_en(rx_en), .tx_en(tx_en),
        .ack_n({ack2_n, ack1_n}), .ack_pins(ack_pins),
        .rx_rd(rx_rd), .tx_wr(tx_wr)
    );

    dma_done_ctl #(.DONE_HOLD(DONE_HOLD)) u_done (
        .clk(clk), .rst_n(rst_n),
        .rx_rd(rx_rd), .rx_last(rx_last), .tx_wr(tx_wr), .tx_tc(tx_tc),
        .done_in_n(done_in_n), .tx_last(tx_last), .done_oe(done_oe)
    );

    assign done_o = 1'b0;

    p_strobe_sa_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd || tx_wr) |-> single_addr);
    p_ackpins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ack_pins == $past({ack2_n, ack1_n})));
endmodule

// File: tb/dma_req_ctl_test.sv
module dma_req_ctl_test;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = '0;
    logic single_addr = 0, rx_en = 0, tx_en = 0, rx_not_empty = 0, tx_not_full = 0;
    logic gpo1 = 0, gpo2 = 0, ack1_n = 1, ack2_n = 1, done_in_n = 1, rx_last = 0, tx_tc = 0;
    logic req1_n, req2_n, rx_rd, tx_wr, tx_last, done_oe, done_o;
    logic [1:0] ack_pins;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    dma_req_ctl #(.DONE_HOLD(HOLD)) uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Expected requests from the mode table.
    function automatic logic [1:0] exp_req(input int m, input logic re, te, rne, tnf, g1, g2);
        logic rw, tw;
        rw = re & rne;
        tw = te & tnf;
        case (m)
            1: return {~g2, ~(rw | tw)};
            2: return {~tw, ~rw};
            default: return {~g2, ~g1};
        endcase
    endfunction

    // Expected strobes {tx_wr, rx_rd} for the given falling acknowledges.
    function automatic logic [1:0] exp_stb(input int m, input logic sa, re, te, f1, f2);
        if (!sa) return 2'b00;
        case (m)
            1: return re ? {1'b0, f1} : (te ? {f1, 1'b0} : 2'b00);
            2: return {f2 & te, f1 & re};
            default: return 2'b00;
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R10 reset state
        chk("R10 ack_pins", ack_pins, 3);
        chk("R10 done_oe", done_oe, 0);
        chk("R10 strobes", {tx_wr, rx_rd}, 0);
        chk("R9 done_o", done_o, 0);

        // R1 R2 R3 request sweep
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 64; v++) begin
                mode = 2'(m);
                {rx_en, tx_en, rx_not_empty, tx_not_full, gpo1, gpo2} = 6'(v);
                #1;
                chk(m == 1 ? "R2 req" : (m == 2 ? "R3 req" : "R1 req"), {req2_n, req1_n},
                    exp_req(m, rx_en, tx_en, rx_not_empty, tx_not_full, gpo1, gpo2));
                step();
            end
        end

        // R4 R5 R6 R7 strobe sweep
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 8; v++) begin
                for (int p = 1; p < 4; p++) begin
                    mode = 2'(m);
                    {single_addr, rx_en, tx_en} = 3'(v);
                    ack1_n = 1; ack2_n = 1;
                    step();
                    ack1_n = ~p[0]; ack2_n = ~p[1];
                    #1;
                    chk(m == 1 ? "R5 strobe" : (m == 2 ? "R6 strobe" : "R4 strobe"), {tx_wr, rx_rd},
                        exp_stb(m, single_addr, rx_en, tx_en, p[0], p[1]));
                    step();
                    chk("R4 one-cycle", {tx_wr, rx_rd}, 0);
                    chk("R7 ack_pins", ack_pins, {~p[1], ~p[0]});
                end
            end
        end
        ack1_n = 1; ack2_n = 1;

        // R8 done input marks last load (half-duplex, tx only)
        for (int d = 0; d < 2; d++) begin
            mode = 2'd1; single_addr = 1; rx_en = 0; tx_en = 1; ack1_n = 1;
            step();
            done_in_n = d[0]; ack1_n = 0;
            #1;
            chk("R8 tx_wr", tx_wr, 1);
            chk("R8 tx_last", tx_last, d == 0 ? 1 : 0);
            step();
            done_in_n = 1;
        end
        ack1_n = 1;
        repeat (HOLD + 1) step();

        // R9 done hold after last rx read (full-duplex)
        mode = 2'd2; single_addr = 1; rx_en = 1; tx_en = 0;
        step();
        chk("R9 idle", done_oe, 0);
        ack1_n = 0; rx_last = 1;
        #1;
        chk("R9 rx_rd", rx_rd, 1);
        for (int k = 0; k < HOLD; k++) begin
            step();
            rx_last = 0;
            chk("R9 hold", done_oe, 1);
        end
        step();
        chk("R9 release", done_oe, 0);
        ack1_n = 1;
        step();

        // R9 read without last flag does not trigger done
        ack1_n = 0;
        step();
        chk("R9 no-last", done_oe, 0);
        ack1_n = 1;

        // R9 terminal count in no-DMA mode
        mode = 2'd0;
        tx_tc = 1;
        step();
        tx_tc = 0;
        for (int k = 0; k < HOLD; k++) begin
            chk("R9 tc hold", done_oe, 1);
            step();
        end
        chk("R9 tc release", done_oe, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule